// File: doc/BRIEF.md
# Fault Status Generator

This block turns the condition flags of one faulting memory access into the two values an exception handler reads first: the offset of the exception vector and a 32-bit word of cause bits. A data access (load or store) is sent to offset 0x00300 and its status word reports every cause that applies. An instruction fetch is sent to offset 0x00400 and reports its own, smaller set of causes.

The classification is combinational. The vector and the status word are captured into registers on the clock edge where the one-cycle `fault_stb` is high. They keep their value until the next strobe, so the handler can read them at any later time. Several causes can be reported in the same status word, and none of them masks another. Status bits are numbered from the most significant end: status bit n is held in `status_q[31-n]`.

Top module: `fault_status_gen`

## Requirements
- R1: On a strobed load or store fault (`acc_kind` 0 = load, 1 = store, 3 = treated as load), `vector_q` becomes 0x00300 one clock later.
- R2: On a strobed fetch fault (`acc_kind` 2), `vector_q` becomes 0x00400 one clock later.
- R3: For a data fault, status bit 0 (`status_q[31]`) equals `dstore_seg`.
- R4: For a data fault, status bit 1 (`status_q[30]`) equals `xlate_miss`.
- R5: For a data fault, status bit 4 (`status_q[27]`) equals `prot_viol`.
- R6: For a data fault, status bit 5 (`status_q[26]`) is set in two cases. The first is when `seg_t` is 1 and `insn_cls` is external-control (1) or reservation (2). The second is when `insn_cls` is external-control and `wthru` is 1. Classes 0 and 3 are plain.
- R7: For a data fault, status bit 6 (`status_q[25]`) is 1 for a store and 0 for a load.
- R8: For a data fault, status bit 9 (`status_q[22]`) equals `brk_hit`.
- R9: For a data fault, status bit 10 (`status_q[21]`) equals `stab_fail`.
- R10: For a data fault, status bit 11 (`status_q[20]`) is set when `insn_cls` is external-control and `ext_en` is 0.
- R11: For a fetch fault, only three bits can be set. Bit 1 (`status_q[30]`) is `xlate_miss` OR `stab_fail`. Bit 3 (`status_q[28]`) is `dstore_seg`. Bit 4 (`status_q[27]`) is `prot_viol`. Every other bit is 0.
- R12: For a data fault, every status bit not named in R3 to R10 is 0. Any combination of the named bits may be set together, with no priority among them.
- R13: Reset clears `vector_q` and `status_q` to 0. Both load only on a clock edge where `fault_stb` is high, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_stb | input | 1 | One-cycle strobe that captures the current fault |
| acc_kind | input | 2 | 0 load, 1 store, 2 fetch, 3 load |
| insn_cls | input | 2 | 0 plain, 1 external-control, 2 reservation, 3 plain |
| xlate_miss | input | 1 | No translation in either page group or any block-address range |
| prot_viol | input | 1 | Page or block protection forbids the access |
| dstore_seg | input | 1 | Access hits a direct-store segment |
| wthru | input | 1 | Target is marked write-through |
| seg_t | input | 1 | Segment T flag |
| brk_hit | input | 1 | Data breakpoint compare hit |
| stab_fail | input | 1 | Segment table search found no translation |
| ext_en | input | 1 | External-access enable bit |
| vector_q | output | 20 | Captured exception vector offset |
| status_q | output | 32 | Captured fault status word |

## Verification
On every clock, the assertions check the following:
- the registers hold between strobes;
- the vector that each access kind selects;
- the store/load bit;
- that no bit outside the legal cause set is ever set.

Only the bench's scenarios can show the rest. These cover the exact value of each cause bit under mixed flag combinations, the two separate conditions behind status bit 5, and the merging of untranslatable causes on fetches. They also show that an access with several causes reports all of them at once.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    localparam int STAT_W = 32;
    localparam int VEC_W  = 20;

    localparam logic [VEC_W-1:0] DATA_VEC  = 20'h00300;
    localparam logic [VEC_W-1:0] FETCH_VEC = 20'h00400;

    // status bit numbers, counted from the most significant end
    localparam int B_DSTORE  = 0;
    localparam int B_NOXLATE = 1;
    localparam int B_IDSTORE = 3;
    localparam int B_PROT    = 4;
    localparam int B_TFLAG   = 5;
    localparam int B_STORE   = 6;
    localparam int B_BRK     = 9;
    localparam int B_STAB    = 10;
    localparam int B_EXTDIS  = 11;

    typedef enum logic [1:0] {
        AK_LOAD  = 2'd0,
        AK_STORE = 2'd1,
        AK_FETCH = 2'd2,
        AK_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        IC_PLAIN = 2'd0,
        IC_EXTC  = 2'd1,
        IC_RESV  = 2'd2,
        IC_OTHER = 2'd3
    } insn_cls_e;

    typedef struct packed {
        acc_kind_e kind;
        insn_cls_e cls;
        logic      xlate_miss;
        logic      prot_viol;
        logic      dstore_seg;
        logic      wthru;
        logic      seg_t;
        logic      brk_hit;
        logic      stab_fail;
        logic      ext_en;
    } fault_in_t;

    function automatic int bpos(input int n);
        return STAT_W - 1 - n;
    endfunction
endpackage

// File: rtl/fsg_data_causes.sv
module fsg_data_causes
    import fsg_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  fault_in_t      fin,
    output logic [W-1:0]   causes
);
    localparam int P_DSTORE  = W - 1 - B_DSTORE;
    localparam int P_NOXLATE = W - 1 - B_NOXLATE;
    localparam int P_PROT    = W - 1 - B_PROT;
    localparam int P_TFLAG   = W - 1 - B_TFLAG;
    localparam int P_STORE   = W - 1 - B_STORE;
    localparam int P_BRK     = W - 1 - B_BRK;
    localparam int P_STAB    = W - 1 - B_STAB;
    localparam int P_EXTDIS  = W - 1 - B_EXTDIS;

    logic is_extc;
    logic is_resv;

    always_comb begin
        is_extc = (fin.cls == IC_EXTC);
        is_resv = (fin.cls == IC_RESV);
        causes  = '0;
        causes[P_DSTORE]  = fin.dstore_seg;
        causes[P_NOXLATE] = fin.xlate_miss;
        causes[P_PROT]    = fin.prot_viol;
        causes[P_TFLAG]   = (fin.seg_t && (is_extc || is_resv)) || (is_extc && fin.wthru);
        causes[P_STORE]   = (fin.kind == AK_STORE);
        causes[P_BRK]     = fin.brk_hit;
        causes[P_STAB]    = fin.stab_fail;
        causes[P_EXTDIS]  = is_extc && !fin.ext_en;
    end
endmodule

// File: rtl/fsg_fetch_causes.sv
module fsg_fetch_causes
    import fsg_pkg::*;
#(
    parameter int W = STAT_W
) (
    input  fault_in_t    fin,
    output logic [W-1:0] causes
);
    localparam int P_NOXLATE = W - 1 - B_NOXLATE;
    localparam int P_IDSTORE = W - 1 - B_IDSTORE;
    localparam int P_PROT    = W - 1 - B_PROT;

    always_comb begin
        causes = '0;
        causes[P_NOXLATE] = fin.xlate_miss || fin.stab_fail;
        causes[P_IDSTORE] = fin.dstore_seg;
        causes[P_PROT]    = fin.prot_viol;
    end
endmodule

// File: rtl/fault_status_gen.sv
module fault_status_gen
    import fsg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_stb,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        insn_cls,
    input  logic              xlate_miss,
    input  logic              prot_viol,
    input  logic              dstore_seg,
    input  logic              wthru,
    input  logic              seg_t,
    input  logic              brk_hit,
    input  logic              stab_fail,
    input  logic              ext_en,
    output logic [VEC_W-1:0]  vector_q,
    output logic [STAT_W-1:0] status_q
);
    localparam logic [STAT_W-1:0] DATA_MASK =
        (STAT_W'(1) << bpos(B_DSTORE)) | (STAT_W'(1) << bpos(B_NOXLATE)) |
        (STAT_W'(1) << bpos(B_PROT))   | (STAT_W'(1) << bpos(B_TFLAG))   |
        (STAT_W'(1) << bpos(B_STORE))  | (STAT_W'(1) << bpos(B_BRK))     |
        (STAT_W'(1) << bpos(B_STAB))   | (STAT_W'(1) << bpos(B_EXTDIS));
    localparam logic [STAT_W-1:0] FETCH_MASK =
        (STAT_W'(1) << bpos(B_NOXLATE)) | (STAT_W'(1) << bpos(B_IDSTORE)) |
        (STAT_W'(1) << bpos(B_PROT));

    typedef struct packed {
        logic [VEC_W-1:0]  vec;
        logic [STAT_W-1:0] stat;
    } fsg_state_t;

    fault_in_t         fin;
    logic [STAT_W-1:0] data_causes;
    logic [STAT_W-1:0] fetch_causes;
    fsg_state_t        st_d, st_q;

    assign fin = '{
        kind:       acc_kind_e'(acc_kind),
        cls:        insn_cls_e'(insn_cls),
        xlate_miss: xlate_miss,
        prot_viol:  prot_viol,
        dstore_seg: dstore_seg,
        wthru:      wthru,
        seg_t:      seg_t,
        brk_hit:    brk_hit,
        stab_fail:  stab_fail,
        ext_en:     ext_en
    };

    fsg_data_causes  #(.W(STAT_W)) u_data  (.fin(fin), .causes(data_causes));
    fsg_fetch_causes #(.W(STAT_W)) u_fetch (.fin(fin), .causes(fetch_causes));

    always_comb begin
        st_d = st_q;
        if (fault_stb) begin
            if (fin.kind == AK_FETCH) begin
                st_d.vec  = FETCH_VEC;
                st_d.stat = fetch_causes;
            end else begin
                st_d.vec  = DATA_VEC;
                st_d.stat = data_causes;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vector_q = st_q.vec;
    assign status_q = st_q.stat;

    // R13
    hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_stb |=> ($stable(vector_q) && $stable(status_q)));

    // R1
    data_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb && acc_kind != 2'd2) |=> (vector_q == 20'h00300));

    // R2
    fetch_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb && acc_kind == 2'd2) |=> (vector_q == 20'h00400));

    // R7
    store_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb && acc_kind != 2'd2) |=> (status_q[25] == $past(acc_kind == 2'd1)));

    // R11
    fetch_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb && acc_kind == 2'd2) |=> ((status_q & ~FETCH_MASK) == '0));

    // R12
    data_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_stb && acc_kind != 2'd2) |=> ((status_q & ~DATA_MASK) == '0));
endmodule

// File: tb/sim_fault_status_gen.sv
`timescale 1ns/1ps
module sim_fault_status_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_stb = 1'b0;
    logic [1:0]  acc_kind = 2'd0;
    logic [1:0]  insn_cls = 2'd0;
    logic        xlate_miss = 1'b0, prot_viol = 1'b0, dstore_seg = 1'b0, wthru = 1'b0;
    logic        seg_t = 1'b0, brk_hit = 1'b0, stab_fail = 1'b0, ext_en = 1'b0;
    logic [19:0] vector_q;
    logic [31:0] status_q;

    int checks = 0;
    int fails  = 0;
    logic [19:0] exp_vec  = '0;
    logic [31:0] exp_stat = '0;

    always #10 clk = ~clk;

    fault_status_gen u0 (
        .clk(clk), .rst_n(rst_n), .fault_stb(fault_stb), .acc_kind(acc_kind),
        .insn_cls(insn_cls), .xlate_miss(xlate_miss), .prot_viol(prot_viol),
        .dstore_seg(dstore_seg), .wthru(wthru), .seg_t(seg_t), .brk_hit(brk_hit),
        .stab_fail(stab_fail), .ext_en(ext_en), .vector_q(vector_q), .status_q(status_q)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit sb(input logic [31:0] w, input int n);
        return w[31-n];
    endfunction

    // compare every field of the outputs against the model
    task automatic compare_all();
        bit fetch_now;
        fetch_now = (exp_vec == 20'h00400);
        if (fetch_now) chk("R2 vector", {12'd0, vector_q}, {12'd0, exp_vec});
        else           chk("R1 vector", {12'd0, vector_q}, {12'd0, exp_vec});
        chk("R3 bit0",  32'(sb(status_q,0)),  32'(sb(exp_stat,0)));
        chk("R4 bit1",  32'(sb(status_q,1)),  32'(sb(exp_stat,1)));
        chk("R5 bit4",  32'(sb(status_q,4)),  32'(sb(exp_stat,4)));
        chk("R6 bit5",  32'(sb(status_q,5)),  32'(sb(exp_stat,5)));
        chk("R7 bit6",  32'(sb(status_q,6)),  32'(sb(exp_stat,6)));
        chk("R8 bit9",  32'(sb(status_q,9)),  32'(sb(exp_stat,9)));
        chk("R9 bit10", 32'(sb(status_q,10)), 32'(sb(exp_stat,10)));
        chk("R10 bit11",32'(sb(status_q,11)), 32'(sb(exp_stat,11)));
        if (fetch_now) chk("R11 fetch word", status_q, exp_stat);
        else           chk("R12 whole word", status_q, exp_stat);
    endtask

    // behavioural reference: what a strobe with the current inputs should capture
    task automatic model_capture();
        logic [31:0] w;
        int  cls;
        w = '0;
        cls = int'(insn_cls);
        if (acc_kind == 2'd2) begin
            exp_vec = 20'h00400;
            if (xlate_miss || stab_fail) w[31-1] = 1'b1;
            if (dstore_seg)              w[31-3] = 1'b1;
            if (prot_viol)               w[31-4] = 1'b1;
        end else begin
            exp_vec = 20'h00300;
            if (dstore_seg) w[31-0] = 1'b1;
            if (xlate_miss) w[31-1] = 1'b1;
            if (prot_viol)  w[31-4] = 1'b1;
            if (seg_t && (cls == 1 || cls == 2)) w[31-5] = 1'b1;
            if (cls == 1 && wthru)               w[31-5] = 1'b1;
            if (acc_kind == 2'd1) w[31-6] = 1'b1;
            if (brk_hit)    w[31-9] = 1'b1;
            if (stab_fail)  w[31-10] = 1'b1;
            if (cls == 1 && !ext_en) w[31-11] = 1'b1;
        end
        exp_stat = w;
    endtask

    task automatic drive(input bit stb, input logic [1:0] k, input logic [1:0] c,
                         input logic [7:0] f);
        fault_stb  = stb;
        acc_kind   = k;
        insn_cls   = c;
        {xlate_miss, prot_viol, dstore_seg, wthru, seg_t, brk_hit, stab_fail, ext_en} = f;
    endtask

    // one cycle: drive at negedge, check at the following negedge
    task automatic step(input bit stb, input logic [1:0] k, input logic [1:0] c,
                        input logic [7:0] f);
        drive(stb, k, c, f);
        if (stb) model_capture();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #4000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk("R13 reset vector", {12'd0, vector_q}, 32'd0);
        chk("R13 reset status", status_q, 32'd0);

        // flag order: xlate,prot,dstore,wthru,seg_t,brk,stab,ext_en
        step(1, 2'd0, 2'd0, 8'b0000_0001);   // R1 plain load, no causes
        step(1, 2'd1, 2'd0, 8'b0010_0001);   // R3 R7 store direct-store
        step(1, 2'd0, 2'd0, 8'b1100_0001);   // R4 R5 together
        step(1, 2'd1, 2'd2, 8'b0000_1001);   // R6 reservation with T
        step(1, 2'd0, 2'd1, 8'b0001_0001);   // R6 ext-control write-through
        step(1, 2'd0, 2'd0, 8'b0001_1001);   // R6 plain: no bit5
        step(1, 2'd1, 2'd1, 8'b0000_0000);   // R10 ext disabled
        step(1, 2'd0, 2'd0, 8'b0000_0110);   // R8 R9
        step(1, 2'd3, 2'd3, 8'b1111_1110);   // R12 all data causes, kind 3 = load
        step(0, 2'd1, 2'd1, 8'b1111_1111);   // R13 no strobe: hold
        step(0, 2'd2, 2'd0, 8'b0000_0000);   // R13 hold
        step(1, 2'd2, 2'd1, 8'b0000_0010);   // R2 R11 fetch, stab fail -> bit1
        step(1, 2'd2, 2'd2, 8'b0111_1100);   // R11 fetch dstore+prot, others ignored
        step(1, 2'd2, 2'd0, 8'b1000_0000);   // R11 fetch translation miss
        step(0, 2'd0, 2'd1, 8'b1111_1111);   // R13 hold after fetch

        for (int i = 0; i < 3000; i++) begin
            step(1'(($urandom % 3) != 0), 2'($urandom), 2'($urandom), 8'($urandom));
        end

        drive(0, 2'd0, 2'd0, 8'd0);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule